// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block lets an 8-bit-data, 16-bit-address processor core reach memory outside the chip. The core presents one request at a time: an address, write data and an access kind (code fetch, data read or data write). The block decides whether the address falls in on-chip space. If it does, it answers at once with a one-clock done pulse and leaves the pins quiet. If it does not, it runs a multiplexed bus cycle. The low address byte goes out on a shared 8-bit bus while an address-latch pulse is high. The high byte sits on a dedicated 8-bit bus for the whole access. Then one active-low strobe runs: a program strobe for fetches, a read strobe for data reads, or a write strobe for data writes.

Code space and data space are decoded separately. Code below 3000h is on chip unless the force-external pin is low, in which case every fetch leaves the chip. Data below 0200h is always on chip. A ready input lets a slow device stretch the strobe, one clock at a time. A float-control pin chooses how the four bus strobes behave while reset is held: they stay driven high, or the block drops their output enable so the pads float.

One clock period corresponds to one oscillator period. The widths of the latch pulse and the strobe, and the sizes of the on-chip spaces, are parameters.

Top module: `xbus_ctrl`

## Requirements
- R1: For an external access, `ale` is high for exactly ALE_CYC clocks (default 3). During those clocks `ad_oe` is 1 and `ad_out` carries address bits 7:0. `ahi` carries address bits 15:8 from the first `ale` clock until the strobe ends.
- R2: The active strobe is low for at least STB_CYC clocks (default 4) and never overlaps `ale`. A read or fetch strobe starts two clocks after the last `ale` clock, which leaves one clock with the bus released. A write strobe starts on the clock right after the last `ale` clock.
- R3: `req_kind` encoding: bit 1 = 1 is a data write and uses `wr_n`; 2'b01 is a data read and uses `rd_n`; 2'b00 is a code fetch and uses `psen_n`. At most one strobe is low at any time, and no other strobe moves during an access.
- R4: A code fetch with an address below ROM_BYTES (default 3000h, so 0000h..2FFFh) is internal when `ext_code_n` is 1. When `ext_code_n` is 0, every fetch is external.
- R5: A data access with an address below RAM_BYTES (default 0200h, so 0000h..01FFh) is internal, and 0200h..FFFFh is external. An internal access raises `done` one clock after acceptance, with no `ale` and no strobe activity.
- R6: `ready` is sampled on each clock edge once the strobe has been low for STB_CYC clocks. Each low sample adds one strobe clock, and the strobe rises at the first edge that samples `ready` high.
- R7: During a read or fetch strobe `ad_oe` is 0. `rdata` takes the `ad_in` value sampled on the edge where the strobe rises, and `done` is high in the clock that follows.
- R8: During a write, `ad_out` carries the write data with `ad_oe` = 1 for every clock that `wr_n` is low and for one further clock after `wr_n` rises. `done` is high in the clock after that hold clock.
- R9: `done` is a single-clock pulse. A request is accepted only while the block is idle and `done` is low. The external latency from acceptance to `done` is ALE_CYC + STB_CYC + 2 + wait clocks for every access kind.
- R10: While `rst_n` is low, `psen_n`, `rd_n` and `wr_n` are 1, `ale` is 0, and `strobe_oe` equals `float_hi`. From the first clock after reset is released, `strobe_oe` is 1, and `done` and `ad_oe` are 0 until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| float_hi | input | 1 | 1: strobes driven high during reset; 0: strobes floated during reset |
| ext_code_n | input | 1 | 0 forces every code fetch external |
| req_valid | input | 1 | Core request present, held until `done` |
| req_kind | input | 2 | Access kind (see R3) |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Data captured from an external read or fetch |
| ready | input | 1 | Low stretches the strobe |
| ad_in | input | 8 | Shared bus input side |
| ad_out | output | 8 | Shared bus output side (low address, then write data) |
| ad_oe | output | 1 | Shared bus output enable |
| ahi | output | 8 | Upper address byte |
| ale | output | 1 | Address latch pulse, active high |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| strobe_oe | output | 1 | Output enable for ale, psen_n, rd_n and wr_n pads |

## Verification
The hardest case to reach is a read whose strobe is stretched by several ready-low samples. In that case the bus value is only correct on the final edge, so a controller that captures too early or too late still looks plausible. The stimulus presents the correct byte on `ad_in` only during the last strobe clock and drives its complement before that. It also pulls `ready` low only after the minimum strobe width has been observed, with the number of wait clocks chosen at random. Boundary addresses 2FFFh/3000h and 01FFh/0200h are hit directly, with the force-external pin at both values.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_TURN = 3'd2,
      ST_STRB = 3'd3,
      ST_HOLD = 3'd4
   } xbus_state_t;

   localparam logic [1:0] KIND_FETCH = 2'b00;
   localparam logic [1:0] KIND_READ  = 2'b01;
   localparam logic [1:0] KIND_WRITE = 2'b10;
endpackage

// File: rtl/xbus_space_dec.sv
module xbus_space_dec #(
   parameter int ADDR_W    = 16,
   parameter int ROM_BYTES = 12288,
   parameter int RAM_BYTES = 512
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_fetch,
   input  logic              ext_code_n,
   output logic              go_ext
);
   logic code_int;
   logic data_int;

   // Each space is either absent (everything external) or a range starting at zero.
   generate
      if (ROM_BYTES == 0) begin : g_no_rom
         assign code_int = 1'b0;
      end else begin : g_rom
         localparam logic [ADDR_W:0] ROM_LIM = ROM_BYTES[ADDR_W:0];
         assign code_int = ({1'b0, addr} < ROM_LIM) && ext_code_n;
      end

      if (RAM_BYTES == 0) begin : g_no_ram
         assign data_int = 1'b0;
      end else begin : g_ram
         localparam logic [ADDR_W:0] RAM_LIM = RAM_BYTES[ADDR_W:0];
         assign data_int = ({1'b0, addr} < RAM_LIM);
      end
   endgenerate

   assign go_ext = is_fetch ? !code_int : !data_int;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int ALE_CYC = 3,
   parameter int STB_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              go_ext,
   input  logic              ready,
   input  logic [DATA_W-1:0] ad_in,
   output xbus_state_t       st,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              wr_q,
   output logic              fetch_q,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   localparam int CNT_MAX = (ALE_CYC > STB_CYC) ? ALE_CYC : STB_CYC;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(ALE_CYC - 1);
   localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STB_CYC - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         wr_q    <= 1'b0;
         fetch_q <= 1'b0;
         done    <= 1'b0;
         rdata   <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (req_valid && !done) begin
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  wr_q    <= req_kind[1];
                  fetch_q <= (req_kind == KIND_FETCH);
                  if (go_ext) begin
                     st  <= ST_ADDR;
                     cnt <= '0;
                  end else begin
                     done <= 1'b1;
                  end
               end
            end
            ST_ADDR: begin
               if (cnt == ALE_LAST) begin
                  cnt <= '0;
                  st  <= wr_q ? ST_STRB : ST_TURN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_TURN: st <= ST_STRB;
            ST_STRB: begin
               if (cnt == STB_LAST) begin
                  if (ready) begin
                     if (wr_q) begin
                        st <= ST_HOLD;
                     end else begin
                        rdata <= ad_in;
                        done  <= 1'b1;
                        st    <= ST_IDLE;
                     end
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_HOLD: begin
               done <= 1'b1;
               st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  xbus_state_t              st,
   input  logic [ADDR_W-1:0]        addr_q,
   input  logic [DATA_W-1:0]        wdata_q,
   input  logic                     wr_q,
   input  logic                     fetch_q,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic [ADDR_W-DATA_W-1:0] ahi,
   output logic                     ale,
   output logic                     psen_n,
   output logic                     rd_n,
   output logic                     wr_n
);
   logic in_strb;
   logic in_wdata;

   assign in_strb  = (st == ST_STRB);
   assign in_wdata = wr_q && (in_strb || (st == ST_HOLD));

   assign ale    = (st == ST_ADDR);
   assign ad_oe  = ale || in_wdata;
   assign ad_out = ale ? addr_q[DATA_W-1:0] : wdata_q;
   assign ahi    = addr_q[ADDR_W-1:DATA_W];
   assign psen_n = !(in_strb && fetch_q);
   assign rd_n   = !(in_strb && !fetch_q && !wr_q);
   assign wr_n   = !(in_strb && wr_q);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int ALE_CYC   = 3,
   parameter int STB_CYC   = 4,
   parameter int ROM_BYTES = 12288,
   parameter int RAM_BYTES = 512
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     float_hi,
   input  logic                     ext_code_n,
   input  logic                     req_valid,
   input  logic [1:0]               req_kind,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     done,
   output logic [DATA_W-1:0]        rdata,
   input  logic                     ready,
   input  logic [DATA_W-1:0]        ad_in,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic [ADDR_W-DATA_W-1:0] ahi,
   output logic                     ale,
   output logic                     psen_n,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     strobe_oe
);
   generate
      if (ALE_CYC < 1)              begin : g_chk_ale  $error("ALE_CYC must be at least 1"); end
      if (STB_CYC < 1)              begin : g_chk_stb  $error("STB_CYC must be at least 1"); end
      if (ADDR_W <= DATA_W)         begin : g_chk_w    $error("ADDR_W must exceed DATA_W"); end
      if (ROM_BYTES > (1 << ADDR_W)) begin : g_chk_rom $error("ROM_BYTES exceeds address space"); end
      if (RAM_BYTES > (1 << ADDR_W)) begin : g_chk_ram $error("RAM_BYTES exceeds address space"); end
   endgenerate

   xbus_state_t       st;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              wr_q;
   logic              fetch_q;
   logic              go_ext;
   logic              rst_q;

   // Remembers that reset is in force so the pad enable follows float_hi until the first clock.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b1;
      else        rst_q <= 1'b0;
   end
   assign strobe_oe = float_hi || !rst_q;

   xbus_space_dec #(
      .ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES)
   ) u_dec (
      .addr(req_addr), .is_fetch(req_kind == KIND_FETCH),
      .ext_code_n(ext_code_n), .go_ext(go_ext)
   );

   xbus_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALE_CYC(ALE_CYC), .STB_CYC(STB_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .go_ext(go_ext),
      .ready(ready), .ad_in(ad_in), .st(st), .addr_q(addr_q),
      .wdata_q(wdata_q), .wr_q(wr_q), .fetch_q(fetch_q),
      .done(done), .rdata(rdata)
   );

   xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .st(st), .addr_q(addr_q), .wdata_q(wdata_q), .wr_q(wr_q),
      .fetch_q(fetch_q), .ad_out(ad_out), .ad_oe(ad_oe), .ahi(ahi),
      .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
   );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
   parameter int ALE_CYC = 3,
   parameter int STB_CYC = 4,
   parameter int HI_W    = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            float_hi,
   input logic            done,
   input logic            ad_oe,
   input logic [HI_W-1:0] ahi,
   input logic            ale,
   input logic            psen_n,
   input logic            rd_n,
   input logic            wr_n,
   input logic            strobe_oe
);
   logic any_lo;
   logic [7:0] ale_run;
   logic [7:0] stb_run;

   assign any_lo = !psen_n || !rd_n || !wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ale_run <= '0;
         stb_run <= '0;
      end else begin
         ale_run <= ale ? ale_run + 8'd1 : 8'd0;
         stb_run <= any_lo ? stb_run + 8'd1 : 8'd0;
      end
   end

   // R1: latch pulse width
   a_r1_ale_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale) |-> (ale_run == 8'(ALE_CYC)));
   // R1: upper address steady while a strobe is low
   a_r1_ahi_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (any_lo && $past(any_lo)) |-> $stable(ahi));
   // R2: minimum strobe width
   a_r2_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(any_lo) |-> (stb_run >= 8'(STB_CYC)));
   // R2: latch pulse and strobe never overlap
   a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> !any_lo);
   // R3: at most one strobe low
   a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!psen_n, !rd_n, !wr_n}));
   // R7: bus released during read strobes
   a_r7_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
      (!psen_n || !rd_n) |-> !ad_oe);
   // R8: write data driven while write strobe low and one clock after
   a_r8_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |=> ad_oe);
   // R9: done lasts one clock
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: pad behaviour while reset is held
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         a_r10_reset_pads: assert (psen_n && rd_n && wr_n && !ale && (strobe_oe == float_hi));
      end
   end
endmodule

bind xbus_ctrl xbus_ctrl_chk #(
   .ALE_CYC(ALE_CYC), .STB_CYC(STB_CYC), .HI_W(ADDR_W - DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .float_hi(float_hi), .done(done), .ad_oe(ad_oe),
   .ahi(ahi), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
   .strobe_oe(strobe_oe)
);

// File: tb/sim_xbus_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_ctrl;
   localparam int ALE = 3;
   localparam int STB = 4;

   logic clk = 1'b0;
   logic rst_n, float_hi, ext_code_n, req_valid, ready;
   logic [1:0] req_kind;
   logic [15:0] req_addr;
   logic [7:0] req_wdata, ad_in;
   logic done, ad_oe, ale, psen_n, rd_n, wr_n, strobe_oe;
   logic [7:0] rdata, ad_out, ahi;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   xbus_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .float_hi(float_hi), .ext_code_n(ext_code_n),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_wdata(req_wdata), .done(done), .rdata(rdata), .ready(ready),
      .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ahi(ahi), .ale(ale),
      .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic bit exp_ext(input logic [1:0] k, input logic [15:0] a, input logic xn);
      if (k == 2'b00) return (!xn) || (a >= 16'h3000);
      return a >= 16'h0200;
   endfunction

   task automatic do_acc(input logic [1:0] k, input logic [15:0] a, input logic [7:0] wd,
                         input int waits);
      bit ext, is_wr, got, hold_ok, prev_wr, lo, other;
      int n, ale_n, stb_n, wrong, last_ale, first_stb, rel_bad, wd_bad, ahi_bad, wg;
      logic [7:0] rdv;
      ext = exp_ext(k, a, ext_code_n);
      is_wr = k[1];
      rdv = 8'($urandom);
      n = 0; ale_n = 0; stb_n = 0; wrong = 0; last_ale = -1; first_stb = -1;
      rel_bad = 0; wd_bad = 0; ahi_bad = 0; wg = 0; got = 0; hold_ok = 0; prev_wr = 0;
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
      ready = 1'b1; ad_in = ~rdv;
      while (!got && n < 100) begin
         @(negedge clk);
         n++;
         lo = (k == 2'b00) ? !psen_n : (is_wr ? !wr_n : !rd_n);
         other = ((!psen_n) + (!rd_n) + (!wr_n)) > (lo ? 1 : 0);
         if (other) wrong++;
         if (ale) begin
            ale_n++; last_ale = n;
            if (!ad_oe || ad_out !== a[7:0]) ahi_bad++;
         end
         if (lo) begin
            stb_n++;
            if (first_stb < 0) first_stb = n;
            if (!is_wr && ad_oe) rel_bad++;
            if (is_wr && (!ad_oe || ad_out !== wd)) wd_bad++;
         end
         if ((ale || lo) && ahi !== a[15:8]) ahi_bad++;
         if (is_wr && prev_wr && wr_n && ad_oe && ad_out === wd) hold_ok = 1;
         prev_wr = is_wr && lo;
         if (lo && stb_n >= STB && wg < waits) begin
            ready = 1'b0; wg++;
         end else begin
            ready = 1'b1;
         end
         ad_in = (lo && stb_n >= STB && ready) ? rdv : ~rdv;
         if (done) got = 1;
      end
      req_valid = 1'b0; ready = 1'b1;
      chk(got, "R9 done seen", got, 1);
      if (ext) begin
         chk(n == ALE + STB + 2 + waits, "R9 external latency", n, ALE + STB + 2 + waits);
         chk(ale_n == ALE, "R1 ale width", ale_n, ALE);
         chk(ahi_bad == 0, "R1 address bytes on bus", ahi_bad, 0);
         chk(stb_n == STB + waits, "R6 strobe width with waits", stb_n, STB + waits);
         chk(wrong == 0, "R3 only the matching strobe", wrong, 0);
         if (is_wr) begin
            chk(first_stb - last_ale == 1, "R2 write strobe start", first_stb - last_ale, 1);
            chk(wd_bad == 0, "R8 write data during strobe", wd_bad, 0);
            chk(hold_ok, "R8 write data hold clock", hold_ok, 1);
         end else begin
            chk(first_stb - last_ale == 2, "R2 read turnaround", first_stb - last_ale, 2);
            chk(rel_bad == 0, "R7 bus released in strobe", rel_bad, 0);
            chk(rdata === rdv, "R7 captured read data", rdata, rdv);
         end
      end else begin
         chk(n == 1, (k == 2'b00) ? "R4 internal fetch latency" : "R5 internal data latency", n, 1);
         chk(ale_n == 0 && stb_n == 0 && wrong == 0,
             (k == 2'b00) ? "R4 internal fetch quiet pins" : "R5 internal quiet pins",
             ale_n + stb_n + wrong, 0);
      end
      @(negedge clk);
      chk(!done, "R9 done single pulse", done, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog expired (R9 completion) actual=%0d expected=0", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; float_hi = 1'b1; ext_code_n = 1'b1; req_valid = 1'b0;
      req_kind = 2'b00; req_addr = '0; req_wdata = '0; ready = 1'b1; ad_in = '0;
      repeat (3) @(negedge clk);
      chk(strobe_oe && psen_n && rd_n && wr_n && !ale, "R10 reset driven high",
          {strobe_oe, psen_n, rd_n, wr_n}, 4'hF);
      float_hi = 1'b0;
      @(negedge clk);
      chk(!strobe_oe, "R10 reset floated", strobe_oe, 0);
      chk(psen_n && rd_n && wr_n, "R10 strobe values in reset", {psen_n, rd_n, wr_n}, 7);
      rst_n = 1'b1;
      @(negedge clk);
      chk(strobe_oe, "R10 enable after reset", strobe_oe, 1);
      chk(!done && !ad_oe && !ale, "R10 idle after reset", {done, ad_oe, ale}, 0);

      // directed corners
      do_acc(2'b00, 16'h2FFF, 8'h00, 0);   // R4 last internal code
      do_acc(2'b00, 16'h3000, 8'h00, 0);   // R4 first external code
      ext_code_n = 1'b0;
      do_acc(2'b00, 16'h0000, 8'h00, 2);   // R4 forced external
      ext_code_n = 1'b1;
      do_acc(2'b01, 16'h01FF, 8'h00, 0);   // R5 last internal data
      do_acc(2'b01, 16'h0200, 8'h00, 5);   // R5/R6 first external data with waits
      do_acc(2'b10, 16'h01FF, 8'hA5, 0);   // R5 internal write
      do_acc(2'b10, 16'h0200, 8'h5A, 3);   // R8 write with waits
      do_acc(2'b11, 16'hFFFF, 8'hC3, 0);   // R3 kind 11 is a write
      do_acc(2'b01, 16'hFFFF, 8'h00, 1);   // R7 top address

      // random mix
      for (int i = 0; i < 200; i++) begin
         logic [1:0] k;
         logic [15:0] a;
         k = 2'($urandom % 4);
         case ($urandom % 4)
            0: a = 16'h2FFE + 16'($urandom % 4);
            1: a = 16'h01FE + 16'($urandom % 4);
            default: a = 16'($urandom);
         endcase
         ext_code_n = ($urandom % 4) != 0;
         do_acc(k, a, 8'($urandom), int'($urandom % 4));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule